// File: doc/BRIEF.md
# ADC Acquisition Phase Sequencer

This block times the acquisition window that comes before a successive-approximation conversion. A one-cycle start pulse delivers a 32-bit channel configuration word. The block captures that word and then steps through the acquisition phases. It drives one switch-control vector cycle by cycle and pulses a completion flag when the window closes. The phases are:

- an optional precharge of the sample capacitor from the low reference, the high reference or the diagnostic reference;
- a mandatory break cycle with every switch open;
- the sampling interval itself.

The sampling interval can be plain input sampling, or one of three modes that use the diagnostic reference:

- the reference overlapped with the input for one period;
- overlap for one period followed by a clean input-only period;
- the reference substituted for the input as a multiplexer self-test.

The precharge length is a global setting that arrives on its own input. From the same word, the block also does three things:

- It latches the pin address for the analog multiplexer and selects which of four neighbouring multiplexers receives it. Only instance 0 may route to a neighbour.
- It drives the select and chip-enable lines of an external analog multiplexer.
- It presents a flag that chooses the alternate calibration set for the conversion that follows.

Top module: `adc_acq_sequencer`

## Requirements
- R1: After reset, the outputs are as follows: `sw_ctl_o` is 0, `busy_o` and `sample_done_o` are low, `mux_grant_o` is 4'b0001, and `ext_sel_o`, `ext_en_o`, `mux_pin_o` and `alt_cal_o` are 0.
- R2: A start pulse seen at a clock edge while idle is accepted, and `busy_o` is high from the next cycle. The switch sequence follows. In the cycle after the last switch cycle, `sample_done_o` is high for exactly one cycle, with `busy_o` low and `sw_ctl_o` at 0.
- R3: A start pulse seen while `busy_o` is high is ignored. The running sequence keeps its length and its switch pattern, and the latched pin address and calibration flag do not change.
- R4: Word bits 13:12 select the precharge. When the field is nonzero, the sequence opens with a precharge lasting `precond_cycles_i` cycles, where 0 counts as 1. `precond_cycles_i` is sampled at the start. During the precharge, `sw_ctl_o` is 6'b000001 for value 1 (low reference), 6'b000010 for value 2 (high reference) and 6'b000100 for value 3 (diagnostic reference).
- R5: A precharge is always followed by exactly one break cycle, in which `sw_ctl_o` is 6'b001000. With a precharge field of 0, there is neither a precharge nor a break cycle, and sampling starts in the first busy cycle.
- R6: Word bits 27:16 hold the sample period T in cycles, and 0 behaves as 1. With an overlap field (bits 15:14) of 0, the sampling interval is T cycles of `sw_ctl_o` at 6'b010000, meaning input only.
- R7: With an overlap field of 1, sampling lasts 2T cycles. The first T cycles have input and diagnostic reference together (6'b110000), and the last T cycles have input only (6'b010000).
- R8: With an overlap field of 2, sampling lasts T cycles with input and diagnostic reference together (6'b110000).
- R9: With an overlap field of 3, sampling lasts T cycles with only the diagnostic reference connected (6'b100000). This is the multiplexer self-test.
- R10: When word bit 11 (external enable) is 1 at an accepted start, `ext_sel_o` takes bits 10:8, and `ext_en_o` is high during the busy cycles. When bit 11 is 0, `ext_sel_o` keeps its previous value and `ext_en_o` stays low.
- R11: On instance 0, an accepted start sets `mux_grant_o` to the one-hot decode of word bits 7:6, so port p gives bit p. On any other instance, `mux_grant_o` stays at 4'b0001.
- R12: An accepted start latches word bits 5:0 onto `mux_pin_o` and bit 31 onto `alt_cal_o`. Both hold until the next accepted start.
- R13: While busy, `sw_ctl_o` has exactly one bit set, except during overlap, when it is exactly 6'b110000. While idle, it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request to begin an acquisition |
| cfg_word_i | input | 32 | Channel configuration word, valid with `start_i` |
| precond_cycles_i | input | PRE_W | Global precharge length in cycles, where 0 acts as 1 |
| sw_ctl_o | output | 6 | Switch controls: bit 0 low-ref precharge, bit 1 high-ref precharge, bit 2 diag precharge, bit 3 break, bit 4 input, bit 5 diag reference |
| busy_o | output | 1 | Acquisition in progress |
| sample_done_o | output | 1 | One-cycle pulse after the acquisition ends |
| mux_pin_o | output | 6 | Latched pin address for the analog multiplexer |
| mux_grant_o | output | 4 | One-hot choice of the multiplexer that receives the pin address |
| ext_sel_o | output | 3 | External multiplexer select, held while disabled |
| ext_en_o | output | 1 | External multiplexer chip enable |
| alt_cal_o | output | 1 | Selects the alternate calibration set |

## Verification
The assertions assume that `start_i` is driven cleanly with respect to the clock and that `cfg_word_i` is stable whenever `start_i` is high. They also assume that `precond_cycles_i` is only read at an accepted start, so changing it mid-sequence is harmless. The bench respects these assumptions by changing inputs only on the falling edge and by holding each word for exactly the cycle of its pulse. The stimulus covers zero and non-zero precharge and sample counts, all four precharge modes and all four overlap modes. It also sends a second start into a running sequence to show that it is ignored. The neighbour-routing assertion relies on the instance number being fixed at elaboration, so the bench builds two instances with different numbers.

// File: rtl/adc_acq_pkg.sv
package adc_acq_pkg;

    localparam int WORD_W  = 32;
    localparam int SAMP_W  = 12;
    localparam int PIN_W   = 6;
    localparam int XSEL_W  = 3;
    localparam int MUX_CNT = 4;
    localparam int SW_W    = 6;

    // switch-control bit positions
    localparam int SW_PRE_LO   = 0;
    localparam int SW_PRE_HI   = 1;
    localparam int SW_PRE_DIAG = 2;
    localparam int SW_GAP      = 3;
    localparam int SW_INPUT    = 4;
    localparam int SW_DREF     = 5;

    localparam logic [SW_W-1:0] SW_OVERLAP = (SW_W'(1) << SW_INPUT) | (SW_W'(1) << SW_DREF);

    typedef enum logic [1:0] {
        PRE_NONE = 2'd0,
        PRE_LO   = 2'd1,
        PRE_HI   = 2'd2,
        PRE_DIAG = 2'd3
    } pre_mode_e;

    typedef enum logic [1:0] {
        OVL_NONE     = 2'd0,
        OVL_SPLIT    = 2'd1,
        OVL_WHOLE    = 2'd2,
        OVL_SELFTEST = 2'd3
    } ovl_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_GAP,
        PH_SAMP_A,
        PH_SAMP_B
    } phase_e;

    typedef struct packed {
        logic              alt_cal;
        logic [SAMP_W-1:0] samp_time;
        ovl_mode_e         ovl;
        pre_mode_e         pre;
        logic              xmux_en;
        logic [XSEL_W-1:0] xmux_sel;
        logic [1:0]        port;
        logic [PIN_W-1:0]  pin;
    } acq_cfg_t;

    function automatic acq_cfg_t unpack_cfg(input logic [WORD_W-1:0] w);
        acq_cfg_t c;
        c.pin       = w[5:0];
        c.port      = w[7:6];
        c.xmux_sel  = w[10:8];
        c.xmux_en   = w[11];
        c.pre       = pre_mode_e'(w[13:12]);
        c.ovl       = ovl_mode_e'(w[15:14]);
        c.samp_time = w[27:16];
        c.alt_cal   = w[31];
        return c;
    endfunction

    // last index of a count that treats zero as one
    function automatic logic [SAMP_W-1:0] samp_last(input logic [SAMP_W-1:0] t);
        return (t == '0) ? '0 : t - SAMP_W'(1);
    endfunction

    function automatic logic [SW_W-1:0] sw_decode(input phase_e ph, input acq_cfg_t c);
        logic [SW_W-1:0] s;
        s = '0;
        unique case (ph)
            PH_PRE: begin
                unique case (c.pre)
                    PRE_LO:   s[SW_PRE_LO]   = 1'b1;
                    PRE_HI:   s[SW_PRE_HI]   = 1'b1;
                    PRE_DIAG: s[SW_PRE_DIAG] = 1'b1;
                    default:  s = '0;
                endcase
            end
            PH_GAP:    s[SW_GAP] = 1'b1;
            PH_SAMP_A: begin
                unique case (c.ovl)
                    OVL_NONE:     s[SW_INPUT] = 1'b1;
                    OVL_SELFTEST: s[SW_DREF]  = 1'b1;
                    default:      s = SW_OVERLAP;
                endcase
            end
            PH_SAMP_B: s[SW_INPUT] = 1'b1;
            default:   s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/acq_cfg_latch.sv
module acq_cfg_latch
    import adc_acq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     accept_i,
    input  acq_cfg_t cfg_in_i,
    output acq_cfg_t cfg_q_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q_o <= '0;
        end else if (accept_i) begin
            cfg_q_o <= cfg_in_i;
        end
    end

endmodule

// File: rtl/acq_phase_fsm.sv
module acq_phase_fsm
    import adc_acq_pkg::*;
#(
    parameter int PRE_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  acq_cfg_t         cfg_in_i,
    input  acq_cfg_t         cfg_q_i,
    input  logic [PRE_W-1:0] precond_i,
    output logic             accept_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [SW_W-1:0]  sw_o
);

    localparam int CNT_W = (PRE_W > SAMP_W) ? PRE_W : SAMP_W;

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic [CNT_W-1:0] pre_last;
    logic [CNT_W-1:0] samp_last_in;
    logic [CNT_W-1:0] samp_last_q;

    assign accept_o     = start_i && (phase_q == PH_IDLE);
    assign pre_last     = (precond_i == '0) ? '0 : CNT_W'(precond_i) - CNT_W'(1);
    assign samp_last_in = CNT_W'(samp_last(cfg_in_i.samp_time));
    assign samp_last_q  = CNT_W'(samp_last(cfg_q_i.samp_time));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (accept_o) begin
                        if (cfg_in_i.pre != PRE_NONE) begin
                            phase_q <= PH_PRE;
                            cnt_q   <= pre_last;
                        end else begin
                            phase_q <= PH_SAMP_A;
                            cnt_q   <= samp_last_in;
                        end
                    end
                end
                PH_PRE: begin
                    if (cnt_q == '0) phase_q <= PH_GAP;
                    else             cnt_q   <= cnt_q - CNT_W'(1);
                end
                PH_GAP: begin
                    phase_q <= PH_SAMP_A;
                    cnt_q   <= samp_last_q;
                end
                PH_SAMP_A: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end else if (cfg_q_i.ovl == OVL_SPLIT) begin
                        phase_q <= PH_SAMP_B;
                        cnt_q   <= samp_last_q;
                    end else begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                PH_SAMP_B: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end else begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy_o = (phase_q != PH_IDLE);
    assign done_o = done_q;
    assign sw_o   = sw_decode(phase_q, cfg_q_i);

    // R13: one switch group at a time, overlap pair the only combination
    a_r13_switch_groups: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (($countones(sw_o) == 1) || (sw_o == SW_OVERLAP)));
    // R13: all switches open while idle
    a_r13_idle_open: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (sw_o == '0));
    // R5: leaving a precharge always passes through the break cycle
    a_r5_break_after_pre: assert property (@(posedge clk) disable iff (rst)
        (|sw_o[SW_PRE_DIAG:SW_PRE_LO]) |=> ((|sw_o[SW_PRE_DIAG:SW_PRE_LO]) || sw_o[SW_GAP]));
    // R5: the break lasts one cycle and is followed by sampling
    a_r5_break_single: assert property (@(posedge clk) disable iff (rst)
        sw_o[SW_GAP] |=> (!sw_o[SW_GAP] && (sw_o[SW_INPUT] || sw_o[SW_DREF])));
    // R2: busy ends exactly when the completion pulse appears
    a_r2_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);
    // R2: completion pulse never overlaps busy and lasts one cycle
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));

endmodule

// File: rtl/acq_route.sv
module acq_route
    import adc_acq_pkg::*;
#(
    parameter int INSTANCE_ID = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               accept_i,
    input  acq_cfg_t           cfg_in_i,
    output logic [PIN_W-1:0]   pin_o,
    output logic [MUX_CNT-1:0] grant_o,
    output logic [XSEL_W-1:0]  xsel_o
);

    logic [MUX_CNT-1:0] grant_next;

    generate
        if (INSTANCE_ID == 0) begin : g_lead
            always_comb begin
                grant_next = '0;
                grant_next[cfg_in_i.port] = 1'b1;
            end
        end else begin : g_local
            assign grant_next = MUX_CNT'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_o   <= '0;
            grant_o <= MUX_CNT'(1);
            xsel_o  <= '0;
        end else if (accept_i) begin
            pin_o   <= cfg_in_i.pin;
            grant_o <= grant_next;
            if (cfg_in_i.xmux_en) xsel_o <= cfg_in_i.xmux_sel;
        end
    end

    // R10: select lines only move on an accepted start with enable set
    a_r10_sel_hold: assert property (@(posedge clk) disable iff (rst)
        !(accept_i && cfg_in_i.xmux_en) |=> $stable(xsel_o));
    // R11: exactly one multiplexer is granted at all times
    a_r11_grant_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(grant_o) == 1);

endmodule

// File: rtl/adc_acq_sequencer.sv
module adc_acq_sequencer
    import adc_acq_pkg::*;
#(
    parameter int PRE_W       = 10,
    parameter int INSTANCE_ID = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [WORD_W-1:0]  cfg_word_i,
    input  logic [PRE_W-1:0]   precond_cycles_i,
    output logic [SW_W-1:0]    sw_ctl_o,
    output logic               busy_o,
    output logic               sample_done_o,
    output logic [PIN_W-1:0]   mux_pin_o,
    output logic [MUX_CNT-1:0] mux_grant_o,
    output logic [XSEL_W-1:0]  ext_sel_o,
    output logic               ext_en_o,
    output logic               alt_cal_o
);

    acq_cfg_t cfg_in;
    acq_cfg_t cfg_q;
    logic     accept;

    assign cfg_in = unpack_cfg(cfg_word_i);

    acq_cfg_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept),
        .cfg_in_i (cfg_in),
        .cfg_q_o  (cfg_q)
    );

    acq_phase_fsm #(.PRE_W(PRE_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .cfg_in_i  (cfg_in),
        .cfg_q_i   (cfg_q),
        .precond_i (precond_cycles_i),
        .accept_o  (accept),
        .busy_o    (busy_o),
        .done_o    (sample_done_o),
        .sw_o      (sw_ctl_o)
    );

    acq_route #(.INSTANCE_ID(INSTANCE_ID)) u_route (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept),
        .cfg_in_i (cfg_in),
        .pin_o    (mux_pin_o),
        .grant_o  (mux_grant_o),
        .xsel_o   (ext_sel_o)
    );

    assign ext_en_o  = busy_o && cfg_q.xmux_en;
    assign alt_cal_o = cfg_q.alt_cal;

    // R3: a start while busy leaves latched channel data untouched
    a_r3_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> ($stable(mux_pin_o) && $stable(alt_cal_o)));
    // R10: external enable never active outside an acquisition
    a_r10_en_only_busy: assert property (@(posedge clk) disable iff (rst)
        ext_en_o |-> busy_o);

endmodule

// File: tb/adc_acq_sequencer_tb_top.sv
`timescale 1ns/1ps
module adc_acq_sequencer_tb_top;

    localparam int PRE_W = 10;

    logic             clk = 1'b0;
    logic             rst;
    logic             start;
    logic [31:0]      word;
    logic [PRE_W-1:0] pcyc;

    logic [5:0] sw;
    logic       busy, done, ext_en, alt_cal;
    logic [5:0] pin;
    logic [3:0] grant;
    logic [2:0] xsel;

    logic [5:0] n1_sw;
    logic       n1_busy, n1_done, n1_ext_en, n1_alt;
    logic [5:0] n1_pin;
    logic [3:0] n1_grant;
    logic [2:0] n1_xsel;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    adc_acq_sequencer #(.PRE_W(PRE_W), .INSTANCE_ID(0)) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .cfg_word_i(word),
        .precond_cycles_i(pcyc), .sw_ctl_o(sw), .busy_o(busy),
        .sample_done_o(done), .mux_pin_o(pin), .mux_grant_o(grant),
        .ext_sel_o(xsel), .ext_en_o(ext_en), .alt_cal_o(alt_cal));

    adc_acq_sequencer #(.PRE_W(PRE_W), .INSTANCE_ID(1)) dut_n1 (
        .clk(clk), .rst(rst), .start_i(start), .cfg_word_i(word),
        .precond_cycles_i(pcyc), .sw_ctl_o(n1_sw), .busy_o(n1_busy),
        .sample_done_o(n1_done), .mux_pin_o(n1_pin), .mux_grant_o(n1_grant),
        .ext_sel_o(n1_xsel), .ext_en_o(n1_ext_en), .alt_cal_o(n1_alt));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit alt, input int st, input int ovl, input int pre,
                                       input bit en, input int sel, input int port, input int p);
        return {alt, 3'b000, 12'(st), 2'(ovl), 2'(pre), en, 3'(sel), 2'(port), 6'(p)};
    endfunction

    function automatic int seq_len(input logic [31:0] w, input int pc);
        int t = (w[27:16] == 0) ? 1 : int'(w[27:16]);
        int p = (pc == 0) ? 1 : pc;
        int n = (w[15:14] == 2'd1) ? 2 * t : t;
        if (w[13:12] != 0) n += p + 1;
        return n;
    endfunction

    function automatic logic [5:0] exp_sw(input logic [31:0] w, input int pc, input int k);
        int t = (w[27:16] == 0) ? 1 : int'(w[27:16]);
        int p = (pc == 0) ? 1 : pc;
        int i = k;
        if (w[13:12] != 0) begin
            if (i < p) return 6'(1) << (w[13:12] - 1);
            i -= p;
            if (i == 0) return 6'b001000;
            i -= 1;
        end
        case (w[15:14])
            2'd0: return 6'b010000;
            2'd1: return (i < t) ? 6'b110000 : 6'b010000;
            2'd2: return 6'b110000;
            default: return 6'b100000;
        endcase
    endfunction

    // runs one acquisition; inj >= 0 pulses a second start with w2 at that busy cycle
    task automatic run_seq(input logic [31:0] w, input int pc, input string req,
                           input int inj, input logic [31:0] w2);
        int total = seq_len(w, pc);
        bit sw_bad = 0, busy_bad = 0, excl_bad = 0;
        logic [5:0] sw_a = 0, sw_e = 0;
        @(negedge clk);
        word = w; pcyc = PRE_W'(pc); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < total; k++) begin
            if (k > 0) @(negedge clk);
            start = 1'b0;
            if (!sw_bad && sw !== exp_sw(w, pc, k)) begin
                sw_bad = 1; sw_a = sw; sw_e = exp_sw(w, pc, k);
            end
            if (busy !== 1'b1 || done !== 1'b0) busy_bad = 1;
            if (!($countones(sw) == 1 || sw == 6'b110000)) excl_bad = 1;
            if (k == 0) chk(ext_en === w[11], "R10 ext_en during busy", 32'(ext_en), 32'(w[11]));
            if (k == inj) begin
                word = w2; pcyc = PRE_W'(1); start = 1'b1;
            end
        end
        chk(!sw_bad, req, 32'(sw_a), 32'(sw_e));
        chk(!busy_bad, "R2 busy high through sequence", 32'(busy), 32'd1);
        chk(!excl_bad, "R13 switch exclusivity", 32'(sw), 32'd0);
        @(negedge clk);
        start = 1'b0;
        chk(done === 1'b1 && busy === 1'b0 && sw === 6'd0, "R2 done pulse cycle",
            {busy, done, sw}, 32'b01000000);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R2 done single cycle", {busy, done}, 32'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; word = '0; pcyc = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(sw === 0 && busy === 0 && done === 0, "R1 reset idle", {busy, done, sw}, 32'd0);
        chk(grant === 4'b0001 && xsel === 0 && ext_en === 0 && pin === 0 && alt_cal === 0,
            "R1 reset outputs", {grant, xsel, ext_en, pin, alt_cal}, 32'h1 << 11);
    endtask

    task automatic t_plain();
        run_seq(mk(0, 5, 0, 0, 0, 0, 0, 1), 3, "R6 plain T=5 R5 no gap", -1, 0);
        run_seq(mk(0, 0, 0, 0, 0, 0, 0, 2), 3, "R6 T=0 acts as 1", -1, 0);
        run_seq(mk(0, 1, 0, 0, 0, 0, 0, 3), 3, "R6 T=1", -1, 0);
    endtask

    task automatic t_precharge();
        run_seq(mk(0, 2, 0, 1, 0, 0, 0, 4), 3, "R4 low-ref precharge R5 gap", -1, 0);
        run_seq(mk(0, 2, 0, 2, 0, 0, 0, 4), 4, "R4 high-ref precharge R5 gap", -1, 0);
        run_seq(mk(0, 2, 0, 3, 0, 0, 0, 4), 2, "R4 diag precharge R5 gap", -1, 0);
        run_seq(mk(0, 3, 0, 1, 0, 0, 0, 4), 0, "R4 precharge count 0 acts as 1", -1, 0);
    endtask

    task automatic t_overlap();
        run_seq(mk(0, 4, 1, 0, 0, 0, 0, 5), 2, "R7 split overlap", -1, 0);
        run_seq(mk(0, 3, 1, 2, 0, 0, 0, 5), 2, "R7 split overlap after precharge", -1, 0);
        run_seq(mk(0, 4, 2, 0, 0, 0, 0, 5), 2, "R8 whole overlap", -1, 0);
        run_seq(mk(0, 4, 3, 0, 0, 0, 0, 5), 2, "R9 self-test diag only", -1, 0);
    endtask

    task automatic t_extmux();
        run_seq(mk(0, 2, 0, 0, 1, 5, 0, 6), 1, "R6 seq for ext enable", -1, 0);
        chk(xsel === 3'd5, "R10 select taken when enabled", 32'(xsel), 32'd5);
        run_seq(mk(0, 2, 0, 0, 0, 2, 0, 6), 1, "R6 seq for ext disable", -1, 0);
        chk(xsel === 3'd5, "R10 select held when disabled", 32'(xsel), 32'd5);
        chk(ext_en === 1'b0, "R10 enable low when idle", 32'(ext_en), 32'd0);
    endtask

    task automatic t_route();
        run_seq(mk(0, 1, 0, 0, 0, 0, 2, 7), 1, "R6 seq for routing", -1, 0);
        chk(grant === 4'b0100, "R11 instance 0 routes port 2", 32'(grant), 32'h4);
        chk(n1_grant === 4'b0001, "R11 other instance keeps own mux", 32'(n1_grant), 32'h1);
        run_seq(mk(0, 1, 0, 0, 0, 0, 3, 7), 1, "R6 seq for routing", -1, 0);
        chk(grant === 4'b1000, "R11 instance 0 routes port 3", 32'(grant), 32'h8);
    endtask

    task automatic t_capture();
        run_seq(mk(1, 2, 0, 0, 0, 0, 0, 6'h2A), 1, "R6 seq for capture", -1, 0);
        chk(pin === 6'h2A && alt_cal === 1'b1, "R12 pin and alt flag latched",
            {pin, alt_cal}, {6'h2A, 1'b1});
        repeat (3) @(negedge clk);
        chk(pin === 6'h2A && alt_cal === 1'b1, "R12 values held while idle",
            {pin, alt_cal}, {6'h2A, 1'b1});
    endtask

    task automatic t_ignore();
        run_seq(mk(0, 6, 0, 1, 0, 0, 0, 6'h11), 2, "R3 sequence unchanged by second start",
                3, mk(1, 1, 3, 0, 1, 7, 1, 6'h3F));
        chk(pin === 6'h11 && alt_cal === 1'b0 && grant === 4'b0001,
            "R3 latched data unchanged", {pin, alt_cal, grant}, {6'h11, 1'b0, 4'b0001});
    endtask

    initial begin
        t_reset();
        t_plain();
        t_precharge();
        t_overlap();
        t_extmux();
        t_route();
        t_capture();
        t_ignore();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule